// File: doc/BRIEF.md
# GPIO Event Steering Mapper

This block takes thirty-two per-GPIO event levels and routes each one onto one of two banks of eight lines. The first bank feeds the interrupt controller and the second feeds the power-management unit. Every GPIO owns a 4-bit routing field. The top bit of the field picks the bank, and the three low bits pick the line within that bank. A per-GPIO enable bit gates the event before routing. When several enabled GPIOs select the same line, they are ORed onto it.

A small register port programs the routing. It has four 32-bit routing registers and two 16-bit enable registers, one for the lower and one for the upper half of the GPIOs. Power-management lines 7 and 6 belong to a standby group. The other lines belong to the working group, and those lines are held low whenever `work_on_i` says the working group is inactive. All sixteen outputs come from flops.

Top module: `stmap_top`

## Requirements
- R1: After reset, every output is 0, and every register location (addresses 0 to 5) reads back 0.
- R2: Addresses 0, 1, 2 and 3 hold the routing registers for GPIO 7..0, 15..8, 23..16 and 31..24. Within a register, GPIO 8k+n uses bits [4n+3:4n]. Address 4 holds the enables for GPIO 15..0 in bits [15:0], and address 5 holds the enables for GPIO 31..16 in bits [15:0]. Bits 31..16 of both enable registers read 0. `cfg_rdata_o` shows the addressed register one clock after the address is presented. Writes to addresses 6 and 7 are ignored, and those addresses read 0.
- R3: A field with bit 3 = 1 routes its GPIO to `pme_o[field[2:0]]`. A field with bit 3 = 0 routes it to `int_o[field[2:0]]`.
- R4: Each output line is the OR of all enabled, active GPIOs whose field selects that line.
- R5: A GPIO whose enable bit is 0 has no effect on any output. An enabled GPIO drives exactly one line, never one in each bank.
- R6: With the reset routing (all fields 0), an enabled active GPIO drives `int_o[0]`.
- R7: While `work_on_i` = 0, `int_o` and `pme_o[5:0]` are 0, and `pme_o[7:6]` keep their routed values.
- R8: Outputs change only at a clock edge. They show the events, enables, routing and `work_on_i` that were present at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 32 | Per-GPIO event levels |
| work_on_i | input | 1 | Working power group active |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Registered read data |
| int_o | output | 8 | Interrupt lines |
| pme_o | output | 8 | Power-management event lines |

## Verification
A corrupted routing field sends an event to the wrong line or the wrong bank. This shows up on `int_o`/`pme_o` one clock after the event is raised, and on `cfg_rdata_o` one clock after the address is read. A stuck or dropped enable bit shows in the same cycle as a missing or spurious line. Faulty standby gating is visible as soon as `work_on_i` falls with a working-group line routed. Each stimulus is scored against an independently computed line pattern on the very next edge.

// File: rtl/stmap_pkg.sv
package stmap_pkg;
    localparam int NUM_SRC    = 32;
    localparam int LINES      = 8;
    localparam int FLD_W      = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 3;
    localparam int STBY_LINES = 2;

    typedef struct packed {
        logic [LINES-1:0] irq;
        logic [LINES-1:0] pme;
    } route_t;
endpackage

// File: rtl/stmap_regs.sv
module stmap_regs
    import stmap_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int FW    = FLD_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [N_SRC*FW-1:0] map_flat,
    output logic [N_SRC-1:0]    en
);
    localparam int NMAP   = (N_SRC * FW) / DW;
    localparam int EN_W   = N_SRC / 2;
    localparam int A_ENLO = NMAP;
    localparam int A_ENHI = NMAP + 1;

    typedef struct packed {
        logic [NMAP-1:0][DW-1:0] map;
        logic [EN_W-1:0]         en_lo;
        logic [EN_W-1:0]         en_hi;
        logic [DW-1:0]           rdata;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        for (int k = 0; k < NMAP; k++) begin
            if (we && addr == AW'(k)) s_d.map[k] = wdata;
            if (addr == AW'(k))       s_d.rdata  = s_q.map[k];
        end
        if (we && addr == AW'(A_ENLO)) s_d.en_lo = wdata[EN_W-1:0];
        if (we && addr == AW'(A_ENHI)) s_d.en_hi = wdata[EN_W-1:0];
        if (addr == AW'(A_ENLO)) s_d.rdata = DW'(s_q.en_lo);
        if (addr == AW'(A_ENHI)) s_d.rdata = DW'(s_q.en_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata    = s_q.rdata;
    assign map_flat = s_q.map;
    assign en       = {s_q.en_hi, s_q.en_lo};
endmodule

// File: rtl/stmap_route.sv
module stmap_route
    import stmap_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int FW    = FLD_W
) (
    input  logic [N_SRC*FW-1:0] map_flat,
    input  logic [N_SRC-1:0]    en,
    input  logic [N_SRC-1:0]    ev,
    output route_t              route
);
    localparam int SEL_W = FW - 1;

    logic [N_SRC-1:0][LINES-1:0] dec_irq;
    logic [N_SRC-1:0][LINES-1:0] dec_pme;

    for (genvar s = 0; s < N_SRC; s++) begin : gen_src
        logic [FW-1:0]    fld;
        logic [LINES-1:0] hot;
        logic             act;
        assign fld        = map_flat[s*FW +: FW];
        assign act        = en[s] & ev[s];
        assign hot        = LINES'(1) << fld[SEL_W-1:0];
        assign dec_pme[s] = (act &  fld[FW-1]) ? hot : '0;
        assign dec_irq[s] = (act & ~fld[FW-1]) ? hot : '0;
    end

    always_comb begin
        route = '0;
        for (int s = 0; s < N_SRC; s++) begin
            route.irq = route.irq | dec_irq[s];
            route.pme = route.pme | dec_pme[s];
        end
    end
endmodule

// File: rtl/stmap_top.sv
module stmap_top
    import stmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] ev_i,
    input  logic              work_on_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic [LINES-1:0]  int_o,
    output logic [LINES-1:0]  pme_o
);
    localparam logic [LINES-1:0] WORK_MASK = LINES'((1 << (LINES - STBY_LINES)) - 1);

    logic [NUM_SRC*FLD_W-1:0] map_flat;
    logic [NUM_SRC-1:0]       ev_en;
    route_t                   route;
    route_t                   out_d, out_q;

    stmap_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we_i),
        .addr     (cfg_addr_i),
        .wdata    (cfg_wdata_i),
        .rdata    (cfg_rdata_o),
        .map_flat (map_flat),
        .en       (ev_en)
    );

    stmap_route u_route (
        .map_flat (map_flat),
        .en       (ev_en),
        .ev       (ev_i),
        .route    (route)
    );

    always_comb begin
        out_d = route;
        if (!work_on_i) begin
            out_d.irq = '0;
            out_d.pme = route.pme & ~WORK_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign int_o = out_q.irq;
    assign pme_o = out_q.pme;
endmodule

// File: rtl/stmap_chk.sv
module stmap_chk
    import stmap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ev_i,
    input logic [NUM_SRC-1:0] en,
    input logic               work_on,
    input logic [LINES-1:0]   int_o,
    input logic [LINES-1:0]   pme_o
);
    logic [NUM_SRC-1:0] act;
    assign act = ev_i & en;

    // R5: nothing enabled and active gives silent outputs
    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |=> (int_o == '0 && pme_o == '0));

    // R7: working group held low while inactive
    a_r7_work_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !work_on |=> (int_o == '0 && pme_o[LINES-STBY_LINES-1:0] == '0));

    // R3: a lone source drives exactly one line
    a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(act) && work_on) |=> ($countones({int_o, pme_o}) == 1));

    // R4: merging never creates more lines than sources
    a_r4_no_extra_lines: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({int_o, pme_o}) <= $countones($past(act))));
endmodule

bind stmap_top stmap_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_i    (ev_i),
    .en      (ev_en),
    .work_on (work_on_i),
    .int_o   (int_o),
    .pme_o   (pme_o)
);

// File: tb/stmap_top_tb_top.sv
module stmap_top_tb_top;
    import stmap_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_SRC-1:0] ev_i = '0;
    logic              work_on_i = 1'b1;
    logic              cfg_we_i = 1'b0;
    logic [ADDR_W-1:0] cfg_addr_i = '0;
    logic [DATA_W-1:0] cfg_wdata_i = '0;
    logic [DATA_W-1:0] cfg_rdata_o;
    logic [LINES-1:0]  int_o, pme_o;

    always #10 clk = ~clk;

    stmap_top dut_i (.*);

    typedef struct {
        logic [LINES-1:0] irq;
        logic [LINES-1:0] pme;
        string            tag;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    logic [3:0][31:0] sh_map = '0;
    logic [15:0]      sh_lo = '0, sh_hi = '0;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (a < 3'd4)       sh_map[a[1:0]] = d;
        else if (a == 3'd4) sh_lo = d[15:0];
        else if (a == 3'd5) sh_hi = d[15:0];
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr_i = a;
        @(negedge clk);
        checks++;
        if (cfg_rdata_o !== exp) begin
            errors++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, a, cfg_rdata_o, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] ev, input logic won, input string tag);
        exp_t e;
        logic [31:0] enb;
        e.irq = '0; e.pme = '0; e.tag = tag;
        enb = {sh_hi, sh_lo};
        for (int s = 0; s < 32; s++) begin
            if (enb[s] && ev[s]) begin
                logic [3:0] f;
                f = sh_map[s / 8][4 * (s % 8) +: 4];
                if (f[3]) e.pme[f[2:0]] = 1'b1;
                else      e.irq[f[2:0]] = 1'b1;
            end
        end
        if (!won) begin
            e.irq = '0;
            e.pme = e.pme & 8'hC0;
        end
        return e;
    endfunction

    // driver: applies stimulus and pushes the expected line pattern
    task automatic drive(input logic [31:0] ev, input logic won, input string tag);
        @(negedge clk);
        ev_i = ev; work_on_i = won;
        sb_q.push_back(model(ev, won, tag));
        wait (sb_q.size() == 0);
    endtask

    // monitor: compare one edge after each push
    initial begin
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            @(posedge clk);
            @(negedge clk);
            e = sb_q[0];
            checks++;
            if (int_o !== e.irq || pme_o !== e.pme) begin
                errors++;
                $display("FAIL %s: got int=%h pme=%h expected int=%h pme=%h",
                         e.tag, int_o, pme_o, e.irq, e.pme);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        checks++;
        if (int_o !== 8'h00 || pme_o !== 8'h00) begin
            errors++;
            $display("FAIL R1 outputs: got %h/%h expected 00/00", int_o, pme_o);
        end
        for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 reg reset");

        // R6 default routing to int line 0
        wr(3'd4, 32'h0000_0020);
        drive(32'h0000_0020, 1'b1, "R6 default int0");

        // R2/R3 routing fields
        wr(3'd0, 32'h00B0_0000);   // GPIO5 -> pme3
        wr(3'd1, 32'h0000_0060);   // GPIO9 -> int6
        wr(3'd2, 32'h0006_0000);   // GPIO20 -> int6
        wr(3'd3, 32'hF000_0000);   // GPIO31 -> pme7
        wr(3'd4, 32'hFFFF_0220);   // enable GPIO5, 9 (upper bits dropped)
        wr(3'd5, 32'h0000_8010);   // enable GPIO20, 31
        rd(3'd0, 32'h00B0_0000, "R2 map0 readback");
        rd(3'd3, 32'hF000_0000, "R2 map3 readback");
        rd(3'd4, 32'h0000_0220, "R2 en_lo upper bits zero");
        rd(3'd5, 32'h0000_8010, "R2 en_hi readback");

        drive(32'h0000_0020, 1'b1, "R3 pme bank line 3");
        drive(32'h0000_0200, 1'b1, "R3 int bank line 6");
        drive(32'h8000_0000, 1'b1, "R3 standby pme7");

        // R4 merge
        drive(32'h0010_0200, 1'b1, "R4 two sources one line");
        drive(32'h8010_0220, 1'b1, "R4 mixed banks");

        // R5 disabled sources ignored
        drive(32'h0000_1000, 1'b1, "R5 disabled GPIO12");
        drive(32'h7FEF_FDDF, 1'b1, "R5 only disabled active");

        // R7 working group gated
        drive(32'h8010_0220, 1'b0, "R7 standby only");
        drive(32'h0000_0020, 1'b0, "R7 pme3 gated");
        drive(32'h8010_0220, 1'b1, "R7 recovery");

        // R8 output holds until the edge
        @(negedge clk);
        ev_i = 32'h0;
        #2;
        checks++;
        if (int_o !== 8'h40 || pme_o !== 8'h88) begin
            errors++;
            $display("FAIL R8 before edge: got %h/%h expected 40/88", int_o, pme_o);
        end
        @(negedge clk);
        checks++;
        if (int_o !== 8'h00 || pme_o !== 8'h00) begin
            errors++;
            $display("FAIL R8 after edge: got %h/%h expected 00/00", int_o, pme_o);
        end

        // R2 unused address ignored
        wr(3'd6, 32'hDEAD_BEEF);
        rd(3'd6, 32'h0, "R2 unused addr reads 0");
        rd(3'd1, 32'h0000_0060, "R2 map1 untouched");
        drive(32'h0000_0200, 1'b1, "R2 routing unchanged");

        done = 1;
        report();
    end
endmodule